// File: doc/BRIEF.md
# Paired Byte FIFOs with Mirrored Threshold and CRC Rollback

This block holds two byte queues of 2^AW entries each (128 by default): one carries received bytes from a packet engine toward a consumer, the other carries bytes to be sent. A single AW-bit threshold code drives a level flag on each queue. The code counts upward for the receive queue and downward for the transmit queue, so one setting leaves the same headroom before the receive queue overflows as before the transmit queue runs dry.

Both data paths use valid/ready. A writer's byte is taken on a clock edge where `*_in_valid` and `*_in_ready` are both high. `*_in_ready` drops only when the queue is full. A reader takes a byte on an edge where `*_out_valid` and `*_out_ready` are both high. `*_out_valid` is high whenever the queue is not empty, and `*_out_data` shows the oldest byte. Asserting valid into a full queue, or ready on an empty one, is not a handshake. It sets a sticky error flag instead. The receive side tracks packet boundaries. When a packet ends with a failed CRC and automatic discard is active, the write position returns to the last packet boundary, or to the read position if the reader has already entered that packet.

Top module: `pf_fifo_pair`

## Requirements
- R1: After reset both fills are 0, `*_in_ready` is 1, `*_out_valid` is 0, all error flags are 0, and automatic discard is armed.
- R2: Each queue returns bytes in write order. `*_in_ready` is 0 exactly when the fill equals 2^AW, and `*_out_valid` is 1 exactly when the fill is non-zero.
- R3: `rx_thr_hit` is 1 exactly when `rx_fill` ≥ `cfg_thr`+1. Code 0 therefore means 1 byte, and code 127 means 128 bytes.
- R4: `tx_thr_hit` is 1 exactly when `tx_fill` ≤ 2^AW−1−`cfg_thr`. Code 0 therefore means 127 bytes, and code 127 means 0 bytes.
- R5: Valid asserted into a full queue drops the byte and sets that queue's `*_ovf`. The flag stays set until that queue's flush strobe.
- R6: Ready asserted on an empty queue sets that queue's `*_unf`. The flag stays set until that queue's flush strobe.
- R7: A flush strobe empties its queue and clears its two error flags on the next edge. It takes precedence over writes and reads in the same cycle.
- R8: When `rx_eop` is high with `rx_crc_ok`=0 while automatic discard is active, the whole current packet is removed. Earlier packets remain intact. If the reader has already taken bytes of that packet, the remaining unread bytes of it are removed.
- R9: An end strobe with `rx_crc_ok`=1 keeps the packet. An end strobe with a failed CRC while `cfg_autoflush`=0 also keeps it.
- R10: After `cfg_autoflush` has been 0, automatic discard stays inactive until `rx_flush` is applied while `cfg_autoflush` is 1.
- R11: A byte accepted in the same cycle as `rx_eop` belongs to the packet that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr | input | AW | Shared threshold code |
| cfg_autoflush | input | 1 | Enable discard of CRC-failed packets |
| rx_in_valid | input | 1 | Receive byte offered |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_in_data | input | DW | Receive byte |
| rx_eop | input | 1 | Packet end strobe |
| rx_crc_ok | input | 1 | CRC result qualifying `rx_eop` |
| rx_flush | input | 1 | Empty receive queue |
| rx_out_valid | output | 1 | Receive byte available |
| rx_out_ready | input | 1 | Consumer takes receive byte |
| rx_out_data | output | DW | Oldest receive byte |
| tx_in_valid | input | 1 | Transmit byte offered |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_in_data | input | DW | Transmit byte |
| tx_flush | input | 1 | Empty transmit queue |
| tx_out_valid | output | 1 | Transmit byte available |
| tx_out_ready | input | 1 | Sender takes transmit byte |
| tx_out_data | output | DW | Oldest transmit byte |
| rx_fill | output | AW+1 | Receive fill level |
| tx_fill | output | AW+1 | Transmit fill level |
| rx_thr_hit | output | 1 | Receive threshold flag |
| tx_thr_hit | output | 1 | Transmit threshold flag |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |

## Verification
The bench walks every fill level from empty to full on both queues and tries every threshold code at each level. This exposes an off-by-one on either side, or a transmit compare that runs in the wrong direction, as a flag edge one byte away from its expected place. It drives valid into a full queue and ready on an empty one, then checks that no byte was stored and that the sticky flags outlive later traffic. A design that lost order or stored the dropped byte would fail the readback. On the receive side it checks rollback that preserves an earlier good packet, rollback after the reader has entered the packet (a naive restore would push the fill negative), and an end strobe that arrives on the last byte. It also checks the off-then-on enable sequence, where a design that re-arms without the flush would discard a packet it should keep.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Direction in which a threshold code is read against a fill level.
  typedef enum logic {
    THR_COUNT_UP   = 1'b0,  // flag while fill > code
    THR_COUNT_DOWN = 1'b1   // flag while fill <= depth-1-code
  } thr_dir_e;
endpackage

// File: rtl/pf_fifo_core.sv
module pf_fifo_core #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          commit,
  input  logic          rollback,
  output logic [AW:0]   fill,
  output logic          ovf,
  output logic          unf
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, mark;
  logic          full, empty, wr_fire, rd_fire;
  logic [PW-1:0] wptr_inc, rptr_nxt, dist_r, dist_w, restore;

  assign empty    = (wptr == rptr);
  assign full     = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign wr_fire  = wr_valid && !full;
  assign rd_fire  = rd_ready && !empty;
  assign wptr_inc = wptr + PW'(wr_fire);
  assign rptr_nxt = rptr + PW'(rd_fire);

  // Roll back to the packet boundary unless the reader is already inside it.
  assign dist_r  = rptr_nxt - mark;
  assign dist_w  = wptr - mark;
  assign restore = (dist_r <= dist_w) ? rptr_nxt : mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      mark <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      mark <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else begin
      rptr <= rptr_nxt;
      if (rollback) begin
        wptr <= restore;
        mark <= restore;
      end else begin
        wptr <= wptr_inc;
        if (commit) mark <= wptr_inc;
      end
      if (wr_valid && full) ovf <= 1'b1;
      if (rd_ready && empty) unf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && !flush) mem[wptr[AW-1:0]] <= wr_data;
  end

  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign rd_data  = mem[rptr[AW-1:0]];
  assign fill     = wptr - rptr;
endmodule

// File: rtl/pf_thr_flag.sv
module pf_thr_flag
  import pf_pkg::*;
#(
  parameter int       AW  = 7,
  parameter thr_dir_e DIR = THR_COUNT_UP
) (
  input  logic [AW:0]   fill,
  input  logic [AW-1:0] thr,
  output logic          hit
);
  generate
    if (DIR == THR_COUNT_UP) begin : g_up
      // reached at fill == code + 1
      assign hit = fill > {1'b0, thr};
    end else begin : g_down
      // depth-1-code equals the bitwise complement of the code
      assign hit = fill <= {1'b0, ~thr};
    end
  endgenerate
endmodule

// File: rtl/pf_autoflush.sv
module pf_autoflush (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic flush,
  output logic active
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b1;
    else if (!cfg_en) armed <= 1'b0;
    else if (flush)   armed <= 1'b1;
  end

  assign active = cfg_en && armed;
endmodule

// File: rtl/pf_fifo_pair.sv
module pf_fifo_pair
  import pf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_thr,
  input  logic          cfg_autoflush,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  input  logic          rx_flush,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  input  logic          tx_flush,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  output logic [AW:0]   rx_fill,
  output logic [AW:0]   tx_fill,
  output logic          rx_thr_hit,
  output logic          tx_thr_hit,
  output logic          rx_ovf,
  output logic          rx_unf,
  output logic          tx_ovf,
  output logic          tx_unf
);
  logic af_active, rx_commit, rx_rollback;

  pf_autoflush u_af (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_autoflush),
    .flush(rx_flush), .active(af_active)
  );

  assign rx_rollback = rx_eop && !rx_crc_ok && af_active;
  assign rx_commit   = rx_eop && !rx_rollback;

  pf_fifo_core #(.DW(DW), .AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .wr_valid(rx_in_valid), .wr_ready(rx_in_ready), .wr_data(rx_in_data),
    .rd_valid(rx_out_valid), .rd_ready(rx_out_ready), .rd_data(rx_out_data),
    .commit(rx_commit), .rollback(rx_rollback),
    .fill(rx_fill), .ovf(rx_ovf), .unf(rx_unf)
  );

  pf_fifo_core #(.DW(DW), .AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .wr_valid(tx_in_valid), .wr_ready(tx_in_ready), .wr_data(tx_in_data),
    .rd_valid(tx_out_valid), .rd_ready(tx_out_ready), .rd_data(tx_out_data),
    .commit(1'b0), .rollback(1'b0),
    .fill(tx_fill), .ovf(tx_ovf), .unf(tx_unf)
  );

  pf_thr_flag #(.AW(AW), .DIR(THR_COUNT_UP)) u_rx_thr (
    .fill(rx_fill), .thr(cfg_thr), .hit(rx_thr_hit)
  );

  pf_thr_flag #(.AW(AW), .DIR(THR_COUNT_DOWN)) u_tx_thr (
    .fill(tx_fill), .thr(cfg_thr), .hit(tx_thr_hit)
  );
endmodule

// File: rtl/pf_fifo_checker.sv
module pf_fifo_checker #(
  parameter int AW = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_in_ready,
  input logic        rx_out_valid,
  input logic        rx_out_ready,
  input logic        rx_eop,
  input logic        rx_crc_ok,
  input logic        rx_flush,
  input logic        tx_in_ready,
  input logic        tx_flush,
  input logic [AW:0] rx_fill,
  input logic [AW:0] tx_fill,
  input logic        rx_thr_hit,
  input logic        tx_thr_hit,
  input logic        rx_ovf,
  input logic        rx_unf,
  input logic        tx_ovf
);
  localparam int DEPTH = 1 << AW;

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill == (AW+1)'(DEPTH)) |-> !rx_in_ready);

  a_r2_tx_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fill == (AW+1)'(DEPTH)) |-> !tx_in_ready);

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill <= (AW+1)'(DEPTH));

  a_r3_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill == '0) |-> !rx_thr_hit);

  a_r4_full_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fill == (AW+1)'(DEPTH)) |-> !tx_thr_hit);

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !rx_flush) |=> rx_ovf);

  a_r5_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_flush) |=> tx_ovf);

  a_r6_unf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && !rx_out_valid && !rx_flush) |=> rx_unf);

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_fill == '0) && !rx_ovf && !rx_unf);

  a_r9_good_end_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && rx_crc_ok && !rx_flush && !(rx_out_valid && rx_out_ready))
      |=> rx_fill >= $past(rx_fill));
endmodule

bind pf_fifo_pair pf_fifo_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_in_ready(rx_in_ready),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok), .rx_flush(rx_flush),
  .tx_in_ready(tx_in_ready), .tx_flush(tx_flush),
  .rx_fill(rx_fill), .tx_fill(tx_fill),
  .rx_thr_hit(rx_thr_hit), .tx_thr_hit(tx_thr_hit),
  .rx_ovf(rx_ovf), .rx_unf(rx_unf), .tx_ovf(tx_ovf)
);

// File: tb/tb_pf_fifo_pair.sv
module tb_pf_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_thr = '0;
  logic cfg_autoflush = 1'b1;
  logic rx_in_valid = 0, rx_eop = 0, rx_crc_ok = 0, rx_flush = 0, rx_out_ready = 0;
  logic tx_in_valid = 0, tx_flush = 0, tx_out_ready = 0;
  logic [DW-1:0] rx_in_data = '0, tx_in_data = '0;
  logic rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [DW-1:0] rx_out_data, tx_out_data;
  logic [AW:0] rx_fill, tx_fill;
  logic rx_thr_hit, tx_thr_hit, rx_ovf, rx_unf, tx_ovf, tx_unf;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_fifo_pair #(.DW(DW), .AW(AW)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rx_push(input int d, input bit eop, input bit ok);
    rx_in_valid = 1; rx_in_data = DW'(d); rx_eop = eop; rx_crc_ok = ok;
    tick();
    rx_in_valid = 0; rx_eop = 0; rx_crc_ok = 0;
  endtask

  task automatic rx_pop(input int exp, input string tag);
    chk(tag, int'(rx_out_valid), 1);
    chk(tag, int'(rx_out_data), exp & 8'hFF);
    rx_out_ready = 1; tick(); rx_out_ready = 0;
  endtask

  task automatic rx_clear();
    rx_flush = 1; tick(); rx_flush = 0;
  endtask

  function automatic int pat(input int i, input int salt);
    return (i * 37 + salt) & 8'hFF;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 rx_fill", int'(rx_fill), 0);
    chk("R1 tx_fill", int'(tx_fill), 0);
    chk("R1 rx_in_ready", int'(rx_in_ready), 1);
    chk("R1 tx_in_ready", int'(tx_in_ready), 1);
    chk("R1 rx_out_valid", int'(rx_out_valid), 0);
    chk("R1 tx_out_valid", int'(tx_out_valid), 0);
    chk("R1 flags", int'({rx_ovf, rx_unf, tx_ovf, tx_unf}), 0);

    // R3 / R2: receive fill sweep against every threshold code
    for (int f = 0; f <= DEPTH; f++) begin
      chk("R2 rx fill", int'(rx_fill), f);
      chk("R2 rx_in_ready", int'(rx_in_ready), (f < DEPTH) ? 1 : 0);
      chk("R2 rx_out_valid", int'(rx_out_valid), (f > 0) ? 1 : 0);
      for (int t = 0; t < DEPTH; t++) begin
        cfg_thr = AW'(t); #1;
        chk("R3 rx_thr_hit", int'(rx_thr_hit), (f >= t + 1) ? 1 : 0);
      end
      if (f < DEPTH) rx_push(pat(f, 5), 0, 0);
    end
    rx_push(8'hEE, 0, 0);
    chk("R5 rx_ovf set", int'(rx_ovf), 1);
    chk("R5 rx fill held", int'(rx_fill), DEPTH);
    for (int i = 0; i < DEPTH; i++) rx_pop(pat(i, 5), "R2 rx order");
    chk("R5 rx_ovf sticky", int'(rx_ovf), 1);
    chk("R2 rx drained", int'(rx_out_valid), 0);
    chk("R6 rx_unf clear", int'(rx_unf), 0);
    rx_out_ready = 1; tick(); rx_out_ready = 0;
    chk("R6 rx_unf set", int'(rx_unf), 1);
    chk("R6 rx fill", int'(rx_fill), 0);
    rx_push(1, 0, 0);
    chk("R6 rx_unf sticky", int'(rx_unf), 1);
    rx_clear();
    chk("R7 rx flush fill", int'(rx_fill), 0);
    chk("R7 rx flush flags", int'({rx_ovf, rx_unf}), 0);

    // R4 / R2: transmit fill sweep
    for (int f = 0; f <= DEPTH; f++) begin
      chk("R2 tx fill", int'(tx_fill), f);
      chk("R2 tx_in_ready", int'(tx_in_ready), (f < DEPTH) ? 1 : 0);
      for (int t = 0; t < DEPTH; t++) begin
        cfg_thr = AW'(t); #1;
        chk("R4 tx_thr_hit", int'(tx_thr_hit), (f <= DEPTH - 1 - t) ? 1 : 0);
      end
      if (f < DEPTH) begin
        tx_in_valid = 1; tx_in_data = DW'(pat(f, 11)); tick(); tx_in_valid = 0;
      end
    end
    tx_in_valid = 1; tx_in_data = 8'h99; tick(); tx_in_valid = 0;
    chk("R5 tx_ovf set", int'(tx_ovf), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 tx order", int'(tx_out_data), pat(i, 11));
      tx_out_ready = 1; tick(); tx_out_ready = 0;
    end
    tx_out_ready = 1; tick(); tx_out_ready = 0;
    chk("R6 tx_unf set", int'(tx_unf), 1);
    chk("R5 tx_ovf sticky", int'(tx_ovf), 1);
    // R7 flush wins over a same-cycle write
    tx_flush = 1; tx_in_valid = 1; tick(); tx_flush = 0; tx_in_valid = 0;
    chk("R7 tx flush fill", int'(tx_fill), 0);
    chk("R7 tx flush flags", int'({tx_ovf, tx_unf}), 0);
    cfg_thr = '0;

    // R8 / R11: good packet kept, failed packet removed
    for (int i = 0; i < 5; i++) rx_push(pat(i, 50), i == 4, 1);
    chk("R11 good end on last byte", int'(rx_fill), 5);
    for (int i = 0; i < 7; i++) rx_push(pat(i, 90), i == 6, 0);
    chk("R8 failed packet removed", int'(rx_fill), 5);
    for (int i = 0; i < 5; i++) rx_pop(pat(i, 50), "R8 earlier packet intact");
    chk("R8 empty after", int'(rx_out_valid), 0);

    // R8: reader already inside the failing packet
    for (int i = 0; i < 6; i++) rx_push(pat(i, 3), 0, 0);
    rx_pop(pat(0, 3), "R8 partial read");
    rx_pop(pat(1, 3), "R8 partial read");
    rx_eop = 1; rx_crc_ok = 0; tick(); rx_eop = 0;
    chk("R8 rest removed", int'(rx_fill), 0);
    chk("R8 no data left", int'(rx_out_valid), 0);
    rx_push(8'h41, 0, 0); rx_push(8'h42, 1, 1);
    chk("R8 pointers sane", int'(rx_fill), 2);
    rx_pop(8'h41, "R8 after rollback"); rx_pop(8'h42, "R8 after rollback");

    // R9 / R10: disabled, then re-enabled without flush
    cfg_autoflush = 0;
    for (int i = 0; i < 4; i++) rx_push(i, i == 3, 0);
    chk("R9 disabled keeps", int'(rx_fill), 4);
    cfg_autoflush = 1; tick();
    for (int i = 0; i < 3; i++) rx_push(i, i == 2, 0);
    chk("R10 inactive until flush", int'(rx_fill), 7);
    rx_clear();
    for (int i = 0; i < 3; i++) rx_push(i, i == 2, 0);
    chk("R10 re-armed by flush", int'(rx_fill), 0);
    for (int i = 0; i < 3; i++) rx_push(i, i == 2, 1);
    chk("R9 good end keeps", int'(rx_fill), 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule